// File: doc/BRIEF.md
# Paged PHY Management Bus Master

This block lets a host reach the registers of one or more physical-layer devices over an 8-bit, strobe-driven management bus. The host sees a small synchronous request port: one offset, a write flag, write data, and a one-cycle completion pulse that carries read data. A separate configuration port holds a 5-bit page value. During each bus access, the page is placed above the 8-bit offset, so the device sees a 13-bit address while the host window stays 256 locations wide.

On the device side the block runs one access at a time. It asserts chip select and address strobe, then the data strobe, and holds the access for a fixed minimum number of clocks. It stretches the access for as long as the shared, active-low wait line is pulled down. The same configuration port sets a control bit that holds the devices in reset. The devices' active-low interrupt line is brought into the clock domain and reported as an active-high status bit.

Top module: `phy_mgmt_master`

## Requirements
- R1: While `phy_cs_n` is low, `phy_addr[12:8]` equals the page that was configured when the request was accepted, and `phy_addr[7:0]` equals the request offset.
- R2: All strobes are active low. Chip select and address strobe go low together in the first access cycle. The data strobe goes low from the second access cycle to the end of the access. `phy_wr` is 1 for a write and 0 for a read.
- R3: `phy_addr` and `phy_wr` stay stable for every cycle of an access. A page write made during an access does not change the address of that access.
- R4: With the default `PARK_ZERO = 1`, `phy_addr[12:8]` is 0 whenever `phy_cs_n` is high.
- R5: When `phy_wait_n` stays high, an access keeps `phy_cs_n` low for exactly `ACCESS_CYCLES` (default 4) clock cycles.
- R6: `phy_wait_n` is sampled at each clock edge. The access ends at the first edge that falls at or after the end of access cycle `ACCESS_CYCLES-1` (counting from 0) and sees `phy_wait_n` high. If wait is low through cycle k, the access therefore lasts max(4, k+2) cycles.
- R7: Read data is captured from `phy_data` at the edge that removes the strobes. It appears on `rsp_rdata` while `rsp_done` is high, and `rsp_done` is high for exactly one cycle, the first cycle with the strobes removed.
- R8: On a write, the block drives `req_wdata` onto `phy_data` only while the data strobe is low, so the device latches the request data at the requested address.
- R9: A request raised while an access is in progress is ignored. No further access starts from it.
- R10: `irq_status` is the inverse of `phy_int_n` after a two-flop synchronizer. It rises at the second clock edge after `phy_int_n` falls.
- R11: `phy_rst_n` is low after reset and stays low while the reset-control bit is 1. It follows the value written through `cfg_we` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the management bus |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Register offset within the page |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with `rsp_done` |
| cfg_we | input | 1 | Load the page and reset-control bit |
| cfg_page | input | 5 | Page value for address bits 12:8 |
| cfg_phy_reset | input | 1 | 1 holds the devices in reset |
| irq_status | output | 1 | Synchronized active-high interrupt |
| phy_cs_n | output | 1 | Chip select, active low |
| phy_as_n | output | 1 | Address strobe, active low |
| phy_ds_n | output | 1 | Data strobe, active low |
| phy_wr | output | 1 | Direction: 1 write, 0 read |
| phy_addr | output | 13 | Paged device address |
| phy_data | inout | 8 | Bidirectional data bus |
| phy_wait_n | input | 1 | Wired-OR wait, active low |
| phy_int_n | input | 1 | Device interrupt, active low |
| phy_rst_n | output | 1 | Device reset, active low |

## Verification
The hardest case to reach is a wait line that is still low when the minimum access length has run out. This must stretch the access exactly until wait releases. A wait pulse that ends early must not stretch it. The bench models the device and pulls wait low for a chosen number of cycles from the start of chip select, with lengths drawn both below and above the minimum. It checks that the measured strobe length matches max(4, k+2). Two more situations need precise timing: a page rewrite and a second request, each injected in the middle of an access. These prove that the running access keeps its address and that the extra request starts no access.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int PAGE_W     = 5;
    localparam int OFS_W      = 8;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = PAGE_W + OFS_W;
    localparam int MIN_CYCLES = 4;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } acc_state_e;

    typedef struct packed {
        logic              write;
        logic [PAGE_W-1:0] page;
        logic [OFS_W-1:0]  ofs;
        logic [DATA_W-1:0] wdata;
    } acc_req_t;

    typedef struct packed {
        logic cs_n;
        logic as_n;
        logic ds_n;
    } strobe_t;

    function automatic strobe_t strobes_for(acc_state_e st);
        strobe_t s;
        unique case (st)
            ST_ADDR: s = '{cs_n: 1'b0, as_n: 1'b0, ds_n: 1'b1};
            ST_DATA: s = '{cs_n: 1'b0, as_n: 1'b0, ds_n: 1'b0};
            default: s = '{cs_n: 1'b1, as_n: 1'b1, ds_n: 1'b1};
        endcase
        return s;
    endfunction

    function automatic logic [ADDR_W-1:0] bus_address(logic active, logic park_zero,
                                                      acc_req_t r);
        logic [PAGE_W-1:0] upper;
        upper = (active || !park_zero) ? r.page : '0;
        return {upper, r.ofs};
    endfunction

endpackage

// File: rtl/phy_cfg_regs.sv
module phy_cfg_regs
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              reset_bit_in,
    output logic [PAGE_W-1:0] page_q,
    output logic              phy_rst_n
);
    logic reset_bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q      <= '0;
            reset_bit_q <= 1'b1;
        end else if (we) begin
            page_q      <= page_in;
            reset_bit_q <= reset_bit_in;
        end
    end

    assign phy_rst_n = ~reset_bit_q;
endmodule

// File: rtl/phy_irq_sync.sv
module phy_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic int_n_async,
    output logic irq
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= int_n_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], int_n_async};
            end
        end
    endgenerate

    assign irq = ~chain[STAGES-1];
endmodule

// File: rtl/phy_access_fsm.sv
module phy_access_fsm
    import phy_mgmt_pkg::*;
#(
    parameter int ACCESS_CYCLES = MIN_CYCLES,
    parameter bit PARK_ZERO     = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [OFS_W-1:0]  req_ofs,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [PAGE_W-1:0] page,
    input  logic              wait_n,
    input  logic [DATA_W-1:0] bus_in,
    output strobe_t           strobes,
    output logic              wr,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int CNT_W = $clog2(ACCESS_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ACCESS_CYCLES - 1);

    acc_state_e        state;
    logic [CNT_W-1:0]  cnt;
    acc_req_t          cur;
    logic              active;
    logic              finish;

    assign active = (state != ST_IDLE);
    assign finish = (state == ST_DATA) && (cnt >= LAST) && wait_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cur   <= '0;
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (req_valid) begin
                        cur.write <= req_write;
                        cur.page  <= page;
                        cur.ofs   <= req_ofs;
                        cur.wdata <= req_wdata;
                        state     <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    cnt   <= CNT_W'(1);
                    state <= ST_DATA;
                end
                ST_DATA: begin
                    if (finish) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                        done  <= 1'b1;
                        if (!cur.write) rdata <= bus_in;
                    end else if (cnt < LAST) begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign strobes = strobes_for(state);
    assign wr      = active & cur.write;
    assign addr    = bus_address(active, PARK_ZERO, cur);
    assign bus_out = cur.wdata;
    assign bus_oe  = (state == ST_DATA) & cur.write;
endmodule

// File: rtl/phy_mgmt_master.sv
module phy_mgmt_master
    import phy_mgmt_pkg::*;
#(
    parameter int ACCESS_CYCLES = MIN_CYCLES,
    parameter bit PARK_ZERO     = 1'b1,
    parameter int IRQ_STAGES    = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              cfg_we,
    input  logic [PAGE_W-1:0] cfg_page,
    input  logic              cfg_phy_reset,
    output logic              irq_status,
    output logic              phy_cs_n,
    output logic              phy_as_n,
    output logic              phy_ds_n,
    output logic              phy_wr,
    output logic [ADDR_W-1:0] phy_addr,
    inout  wire  [DATA_W-1:0] phy_data,
    input  logic              phy_wait_n,
    input  logic              phy_int_n,
    output logic              phy_rst_n
);
    logic [PAGE_W-1:0] page_q;
    strobe_t           strobes;
    logic [DATA_W-1:0] bus_out;
    logic              bus_oe;

    phy_cfg_regs u_cfg (
        .clk          (clk),
        .rst          (rst),
        .we           (cfg_we),
        .page_in      (cfg_page),
        .reset_bit_in (cfg_phy_reset),
        .page_q       (page_q),
        .phy_rst_n    (phy_rst_n)
    );

    phy_irq_sync #(.STAGES(IRQ_STAGES)) u_irq (
        .clk         (clk),
        .rst         (rst),
        .int_n_async (phy_int_n),
        .irq         (irq_status)
    );

    phy_access_fsm #(
        .ACCESS_CYCLES (ACCESS_CYCLES),
        .PARK_ZERO     (PARK_ZERO)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ofs   (req_offset),
        .req_wdata (req_wdata),
        .page      (page_q),
        .wait_n    (phy_wait_n),
        .bus_in    (phy_data),
        .strobes   (strobes),
        .wr        (phy_wr),
        .addr      (phy_addr),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .done      (rsp_done),
        .rdata     (rsp_rdata)
    );

    assign phy_cs_n = strobes.cs_n;
    assign phy_as_n = strobes.as_n;
    assign phy_ds_n = strobes.ds_n;
    assign phy_data = bus_oe ? bus_out : 'z;
endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker
    import phy_mgmt_pkg::*;
#(
    parameter int ACCESS_CYCLES = MIN_CYCLES,
    parameter bit PARK_ZERO     = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              as_n,
    input logic              ds_n,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic              wait_n,
    input logic              done,
    input logic              oe,
    input logic              cfg_we,
    input logic              cfg_rst_bit,
    input logic              rst_n_out
);
    logic [7:0] cs_len;

    always_ff @(posedge clk) begin
        if (rst)                cs_len <= '0;
        else if (cs_n)          cs_len <= '0;
        else if (cs_len != '1)  cs_len <= cs_len + 8'd1;
    end

    AST_DS_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
        !ds_n |-> (!cs_n && !as_n)); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n)) |-> ($stable(addr) && $stable(wr))); // R3
    AST_PAGE_PARKED: assert property (@(posedge clk) disable iff (rst)
        (PARK_ZERO && cs_n) |-> (addr[ADDR_W-1:OFS_W] == '0)); // R4
    AST_MIN_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (cs_len >= 8'(ACCESS_CYCLES))); // R5
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ds_n && !wait_n) |=> !cs_n); // R6
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && $past(!cs_n))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        oe |-> (!ds_n && wr)); // R8
    AST_PHY_RESET: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_rst_bit) |=> !rst_n_out); // R11
endmodule

bind phy_mgmt_master phy_mgmt_checker #(
    .ACCESS_CYCLES (ACCESS_CYCLES),
    .PARK_ZERO     (PARK_ZERO)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (phy_cs_n),
    .as_n        (phy_as_n),
    .ds_n        (phy_ds_n),
    .wr          (phy_wr),
    .addr        (phy_addr),
    .wait_n      (phy_wait_n),
    .done        (rsp_done),
    .oe          (bus_oe),
    .cfg_we      (cfg_we),
    .cfg_rst_bit (cfg_phy_reset),
    .rst_n_out   (phy_rst_n)
);

// File: tb/tb_phy_mgmt_master.sv
module tb_phy_mgmt_master;
    localparam int ACC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_offset = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_page = '0;
    logic        cfg_phy_reset = 1'b1;
    logic        irq_status;
    logic        phy_cs_n, phy_as_n, phy_ds_n, phy_wr;
    logic [12:0] phy_addr;
    wire  [7:0]  phy_data;
    logic        phy_wait_n;
    logic        phy_int_n = 1'b1;
    logic        phy_rst_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    phy_mgmt_master dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .cfg_we(cfg_we), .cfg_page(cfg_page), .cfg_phy_reset(cfg_phy_reset),
        .irq_status(irq_status),
        .phy_cs_n(phy_cs_n), .phy_as_n(phy_as_n), .phy_ds_n(phy_ds_n),
        .phy_wr(phy_wr), .phy_addr(phy_addr), .phy_data(phy_data),
        .phy_wait_n(phy_wait_n), .phy_int_n(phy_int_n), .phy_rst_n(phy_rst_n)
    );

    // Device model
    int         wait_len = 0;
    int         cs_cnt = 0;
    logic [7:0] cap_data = '0;
    logic [12:0] cap_addr = '0;

    function automatic logic [7:0] dev_value(logic [12:0] a);
        return a[7:0] ^ {a[12:8], a[12:10]} ^ 8'h5A;
    endfunction

    assign phy_data   = (!phy_cs_n && !phy_wr) ? dev_value(phy_addr) : 8'hzz;
    assign phy_wait_n = !(!phy_cs_n && (cs_cnt < wait_len));

    always @(posedge clk) begin
        cs_cnt <= phy_cs_n ? 0 : cs_cnt + 1;
        if (!phy_ds_n && phy_wr) begin
            cap_data <= phy_data;
            cap_addr <= phy_addr;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    logic [4:0] cur_page = '0;
    logic       cur_rst_bit = 1'b1;

    task automatic write_cfg(input logic [4:0] pg, input logic rb);
        @(negedge clk);
        cfg_we = 1'b1; cfg_page = pg; cfg_phy_reset = rb;
        @(negedge clk);
        cfg_we = 1'b0;
        cur_page = pg; cur_rst_bit = rb;
    endtask

    // One access; optionally inject a busy request or a page rewrite mid-access.
    task automatic do_access(input logic wr_en, input logic [7:0] ofs, input logic [7:0] wd,
                             input int wlen, input bit inject, input bit repage,
                             input logic [4:0] new_page);
        int cs_len = 0;
        int addr_bad = 0;
        int strobe_bad = 0;
        int guard = 0;
        logic [12:0] exp_addr;
        int exp_len;
        exp_addr = {cur_page, ofs};
        exp_len  = (wlen + 1 > ACC) ? wlen + 1 : ACC;
        wait_len = wlen;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr_en; req_offset = ofs; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done && guard < 200) begin
            req_valid = 1'b0;
            cfg_we = 1'b0;
            if (!phy_cs_n) begin
                cs_len++;
                if (phy_addr !== exp_addr || phy_wr !== wr_en) addr_bad++;
                if (phy_as_n !== 1'b0) strobe_bad++;
                if (cs_len == 1 && phy_ds_n !== 1'b1) strobe_bad++;
                if (cs_len >= 2 && phy_ds_n !== 1'b0) strobe_bad++;
                if (inject && cs_len == 2) begin
                    req_valid = 1'b1; req_offset = ~ofs; req_write = 1'b0;
                end
                if (repage && cs_len == 2) begin
                    cfg_we = 1'b1; cfg_page = new_page; cfg_phy_reset = cur_rst_bit;
                end
            end
            guard++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        cfg_we = 1'b0;
        if (repage) cur_page = new_page;
        chk("R5/R6 done reached", 32'(guard < 200), 32'd1);
        chk("R5/R6 access length", 32'(cs_len), 32'(exp_len));
        chk("R1/R3 address during access", 32'(addr_bad), 32'd0);
        chk("R2 strobe sequence", 32'(strobe_bad), 32'd0);
        chk("R7 strobes removed with done", {phy_cs_n, phy_as_n, phy_ds_n}, 32'h7);
        chk("R4 page parked", 32'(phy_addr[12:8]), 32'd0);
        if (!wr_en) chk("R7 read data", 32'(rsp_rdata), 32'(dev_value(exp_addr)));
        else begin
            chk("R8 write data", 32'(cap_data), 32'(wd));
            chk("R8 write address", 32'(cap_addr), 32'(exp_addr));
        end
        @(negedge clk);
        chk("R7 done single cycle", 32'(rsp_done), 32'd0);
        if (inject) begin
            int starts = 0;
            for (int i = 0; i < 4; i++) begin
                if (!phy_cs_n) starts++;
                @(negedge clk);
            end
            chk("R9 busy request ignored", 32'(starts), 32'd0);
        end
        wait_len = 0;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset strobes idle", {phy_cs_n, phy_as_n, phy_ds_n}, 32'h7);
        chk("R7 reset done low", 32'(rsp_done), 32'd0);
        chk("R11 reset holds device reset", 32'(phy_rst_n), 32'd0);
        chk("R10 reset irq low", 32'(irq_status), 32'd0);
        chk("R4 reset page parked", 32'(phy_addr[12:8]), 32'd0);

        write_cfg(5'd3, 1'b0);
        chk("R11 device reset released", 32'(phy_rst_n), 32'd1);

        // Directed accesses
        do_access(1'b0, 8'h12, 8'h00, 0, 1'b0, 1'b0, 5'd0);
        do_access(1'b1, 8'hA5, 8'h3C, 0, 1'b0, 1'b0, 5'd0);
        do_access(1'b0, 8'h40, 8'h00, 2, 1'b0, 1'b0, 5'd0); // R6 short wait, no stretch
        do_access(1'b0, 8'h41, 8'h00, 4, 1'b0, 1'b0, 5'd0); // R6 stretch to 5
        do_access(1'b1, 8'h42, 8'h99, 7, 1'b0, 1'b0, 5'd0); // R6 stretch to 8
        do_access(1'b0, 8'h77, 8'h00, 0, 1'b1, 1'b0, 5'd0); // R9
        do_access(1'b0, 8'hFF, 8'h00, 1, 1'b0, 1'b1, 5'd31); // R3 repage mid-access
        do_access(1'b1, 8'h00, 8'hE1, 0, 1'b0, 1'b0, 5'd0); // R1 uses new page 31

        // Device reset control
        write_cfg(cur_page, 1'b1);
        chk("R11 device reset reasserted", 32'(phy_rst_n), 32'd0);
        write_cfg(cur_page, 1'b0);
        chk("R11 device reset released again", 32'(phy_rst_n), 32'd1);

        // Interrupt synchronizer
        @(negedge clk);
        phy_int_n = 1'b0;
        @(negedge clk);
        chk("R10 irq after one edge", 32'(irq_status), 32'd0);
        @(negedge clk);
        chk("R10 irq after two edges", 32'(irq_status), 32'd1);
        phy_int_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 irq cleared", 32'(irq_status), 32'd0);

        // Random accesses
        for (int k = 0; k < 40; k++) begin
            logic [4:0] pg;
            pg = 5'($urandom % 32);
            write_cfg(pg, 1'b0);
            do_access(1'($urandom % 2), 8'($urandom), 8'($urandom),
                      int'($urandom % 8), 1'($urandom % 4 == 0), 1'b0, 5'd0);
        end
        finish_run();
    end
endmodule